// File: doc/BRIEF.md
# Unaligned Partial-Word Store Aligner

This block sits between a processor's store path and a little-endian 32-bit memory write port. For each request it takes a store kind, a base address, a signed 16-bit displacement and a 32-bit register value. From these it forms the effective address. It then produces one write: a word-aligned address, the register bytes moved onto the right lanes, a byte-enable mask and an error flag.

It handles byte, halfword and word stores. It also handles two unaligned-word partial stores. The "right" store fills a word from the addressed byte up to its top byte, taking register bytes from the bottom. The "left" store fills a word from its bottom byte up to the addressed byte, taking register bytes from the top. Used as a pair, they write any unaligned 32-bit word in two accesses. Used alone, they paint the ragged start or end of a byte run with a single write.

Requests enter through a valid/ready handshake. Each accepted request is held in a single output register until the memory port takes it.

Top module: `store_aligner`

## Requirements
- R1: After reset, wr_valid_o is 0 and req_ready_o is 1.
- R2: The effective address is req_base_i plus req_offset_i sign-extended to ADDR_W bits, modulo 2^ADDR_W. wr_addr_o is that address with bits 1:0 forced to 0. Below, k is bits 1:0 of the effective address.
- R3: Byte store (op code 0) enables only lane k and places register bits 7:0 on it. Lane n of the data bus is bits 8n+7:8n, and lane 0 is the least significant memory byte.
- R4: Halfword store (op code 1) with k even enables lanes k and k+1, carrying register bytes 0 and 1 respectively.
- R5: Word store (op code 2) with k = 0 enables all four lanes, and wr_data_o equals the register value.
- R6: Right store (op code 3) enables lanes k through 3. Lane k+j carries register byte j. At k = 0 it matches a word store, and at k = 3 only lane 3 is written, with register byte 0.
- R7: Left store (op code 4) enables lanes 0 through k. Lane j carries register byte 3-k+j. At k = 3 all lanes are written, and at k = 0 only lane 0 is written, with register byte 3.
- R8: The following set wr_err_o to 1 with wr_be_o equal to 0: a halfword store with odd k, a word store with k not 0, and op codes 5 to 7. Every other op sets wr_err_o to 0.
- R9: Every lane whose enable bit is 0 drives 0 on wr_data_o.
- R10: A request is taken on a rising edge where req_valid_i and req_ready_o are both 1. Its result appears on wr_* after that edge, with wr_valid_o at 1. While wr_valid_o is 1 and wr_ready_i is 0, req_ready_o is 0 and every wr_* output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Store request present |
| req_ready_o | output | 1 | Block can take a request this cycle |
| req_op_i | input | 3 | Store kind: 0 byte, 1 halfword, 2 word, 3 right, 4 left |
| req_base_i | input | ADDR_W | Base byte address |
| req_offset_i | input | OFS_W | Signed byte displacement |
| req_data_i | input | 32 | Register value to store |
| wr_valid_o | output | 1 | Write present on the memory side |
| wr_ready_i | input | 1 | Memory port takes the write |
| wr_addr_o | output | ADDR_W | Word-aligned write address |
| wr_data_o | output | 32 | Lane-steered write data |
| wr_be_o | output | 4 | Byte enables, bit n for lane n |
| wr_err_o | output | 1 | Misaligned or unknown store |

## Verification
The bench builds the block with ADDR_W = 20 and OFS_W = 16. The narrow address lets a base near the top of the space, plus a positive displacement, wrap past zero, so modulo addressing is checked without huge constants. Negative displacements move the effective address below the base. Every store kind is driven at all four byte offsets, with distinct byte values in each register lane, so a wrong lane or a wrong byte shows up in the data. The downstream ready follows a pseudo-random pattern, which produces back-to-back transfers as well as multi-cycle stalls.

// File: rtl/store_align_pkg.sv
package store_align_pkg;
  typedef enum logic [2:0] {
    OP_BYTE  = 3'd0,
    OP_HALF  = 3'd1,
    OP_WORD  = 3'd2,
    OP_RIGHT = 3'd3,
    OP_LEFT  = 3'd4
  } st_op_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/store_addr_gen.sv
module store_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [1:0]        byte_ofs_o
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] eff_addr;

  assign ofs_ext     = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
  assign eff_addr    = base_i + ofs_ext;
  assign word_addr_o = {eff_addr[ADDR_W-1:2], 2'b00};
  assign byte_ofs_o  = eff_addr[1:0];
endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer
  import store_align_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [1:0]       ofs_i,
  input  logic [31:0]      data_i,
  output logic [LANES-1:0] be_o,
  output logic [31:0]      data_o,
  output logic             err_o
);
  logic [LANES-1:0] be_raw;
  logic [31:0]      data_raw;
  logic [4:0]       sh_up;
  logic [4:0]       sh_dn;

  assign sh_up = {ofs_i, 3'b000};
  assign sh_dn = {~ofs_i, 3'b000};

  always_comb begin
    be_raw   = '0;
    data_raw = '0;
    err_o    = 1'b0;
    unique case (op_i)
      OP_BYTE: begin
        be_raw   = 4'b0001 << ofs_i;
        data_raw = {4{data_i[7:0]}};
      end
      OP_HALF: begin
        if (ofs_i[0]) begin
          err_o = 1'b1;
        end else begin
          be_raw   = 4'b0011 << ofs_i;
          data_raw = {2{data_i[15:0]}};
        end
      end
      OP_WORD: begin
        if (ofs_i != 2'd0) begin
          err_o = 1'b1;
        end else begin
          be_raw   = 4'b1111;
          data_raw = data_i;
        end
      end
      OP_RIGHT: begin
        be_raw   = 4'b1111 << ofs_i;
        data_raw = data_i << sh_up;
      end
      OP_LEFT: begin
        be_raw   = 4'b1111 >> (~ofs_i);
        data_raw = data_i >> sh_dn;
      end
      default: err_o = 1'b1;
    endcase
  end

  assign be_o = be_raw;

  // Disabled lanes are forced to zero
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_o[8*g +: 8] = be_raw[g] ? data_raw[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/store_out_stage.sv
module store_out_stage #(
  parameter int unsigned PAY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PAY_W-1:0] in_pay_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PAY_W-1:0] out_pay_o
);
  logic             vld_q;
  logic [PAY_W-1:0] pay_q;
  logic             load;

  assign in_ready_o = ~vld_q | out_ready_i;
  assign load       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else begin
      if (in_ready_o) vld_q <= in_valid_i;
      if (load)       pay_q <= in_pay_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_pay_o   = pay_q;
endmodule

// File: rtl/store_aligner.sv
module store_aligner
  import store_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [OFS_W-1:0]  req_offset_i,
  input  logic [31:0]       req_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        wr_be_o,
  output logic              wr_err_o
);
  localparam int unsigned PAY_W = ADDR_W + 32 + LANES + 1;

  logic [ADDR_W-1:0] word_addr;
  logic [1:0]        byte_ofs;
  logic [LANES-1:0]  be_c;
  logic [31:0]       data_c;
  logic              err_c;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  store_addr_gen #(
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W)
  ) u_addr (
    .base_i     (req_base_i),
    .ofs_i      (req_offset_i),
    .word_addr_o(word_addr),
    .byte_ofs_o (byte_ofs)
  );

  store_lane_steer u_steer (
    .op_i  (req_op_i),
    .ofs_i (byte_ofs),
    .data_i(req_data_i),
    .be_o  (be_c),
    .data_o(data_c),
    .err_o (err_c)
  );

  assign pay_in = {word_addr, data_c, be_c, err_c};

  store_out_stage #(
    .PAY_W(PAY_W)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (req_valid_i),
    .in_ready_o (req_ready_o),
    .in_pay_i   (pay_in),
    .out_valid_o(wr_valid_o),
    .out_ready_i(wr_ready_i),
    .out_pay_o  (pay_out)
  );

  assign {wr_addr_o, wr_data_o, wr_be_o, wr_err_o} = pay_out;
endmodule

// File: rtl/store_aligner_chk.sv
module store_aligner_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [31:0]       wr_data_o,
  input logic [3:0]        wr_be_o,
  input logic              wr_err_o
);
  // R2
  word_addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_addr_o[1:0] == 2'b00);

  // R8
  err_no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_err_o) |-> wr_be_o == 4'b0000);

  // R3
  good_store_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_err_o) |-> wr_be_o != 4'b0000);

  // R9
  idle_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ((wr_data_o & ~{{8{wr_be_o[3]}}, {8{wr_be_o[2]}},
                                   {8{wr_be_o[1]}}, {8{wr_be_o[0]}}}) == 32'h0));

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) &&
      $stable(wr_data_o) && $stable(wr_be_o) && $stable(wr_err_o)));

  // R10
  stall_backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |-> !req_ready_o);
endmodule

bind store_aligner store_aligner_chk #(
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_be_o    (wr_be_o),
  .wr_err_o   (wr_err_o)
);

// File: tb/store_aligner_tb.sv
module store_aligner_tb;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned OFS_W  = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
    logic [3:0]        be;
    logic              err;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [2:0]        req_op_i = '0;
  logic [ADDR_W-1:0] req_base_i = '0;
  logic [OFS_W-1:0]  req_offset_i = '0;
  logic [31:0]       req_data_i = '0;
  logic              wr_valid_o;
  logic              wr_ready_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [31:0]       wr_data_o;
  logic [3:0]        wr_be_o;
  logic              wr_err_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t exp_q[$];
  string tag_q[$];
  logic [7:0] lfsr = 8'hA5;
  logic rdy_random = 1'b0;
  logic held = 1'b0;
  exp_t held_v;

  always #5 clk_i = ~clk_i;

  store_aligner #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_base_i(req_base_i),
    .req_offset_i(req_offset_i), .req_data_i(req_data_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_be_o(wr_be_o), .wr_err_o(wr_err_o)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [ADDR_W-1:0] base,
                                 input logic [OFS_W-1:0] ofs, input logic [31:0] d);
    exp_t e;
    logic [ADDR_W-1:0] ea;
    int k;
    ea = base + {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    k = int'(ea[1:0]);
    e.addr = ea & ~(ADDR_W'(3));
    e.data = '0;
    e.be = '0;
    e.err = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int src;
      src = -1;
      case (op)
        3'd0: if (i == k) src = 0;
        3'd1: if (k % 2 == 0 && (i == k || i == k + 1)) src = i - k;
        3'd2: if (k == 0) src = i;
        3'd3: if (i >= k) src = i - k;
        3'd4: if (i <= k) src = i + 3 - k;
        default: src = -1;
      endcase
      if (src >= 0) begin
        e.be[i] = 1'b1;
        e.data[8*i +: 8] = d[8*src +: 8];
      end
    end
    if ((op == 3'd1 && k % 2 == 1) || (op == 3'd2 && k != 0) || op > 3'd4) e.err = 1'b1;
    return e;
  endfunction

  task automatic send(input logic [2:0] op, input logic [ADDR_W-1:0] base,
                      input logic [OFS_W-1:0] ofs, input logic [31:0] d, input string tag);
    @(negedge clk_i);
    req_op_i     = op;
    req_base_i   = base;
    req_offset_i = ofs;
    req_data_i   = d;
    req_valid_i  = 1'b1;
    exp_q.push_back(model(op, base, ofs, d));
    tag_q.push_back(tag);
    forever begin
      #2;
      if (req_ready_o) begin
        @(posedge clk_i);
        break;
      end
      @(negedge clk_i);
    end
    #1 req_valid_i = 1'b0;
  endtask

  // downstream ready pattern
  always @(negedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready_i <= rdy_random ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    #3;
    if (rst_ni) begin
      if (held) begin
        check(wr_valid_o && {wr_addr_o, wr_data_o, wr_be_o, wr_err_o} == held_v, "R10",
              $sformatf("stall hold got %h exp %h", {wr_addr_o, wr_data_o, wr_be_o, wr_err_o}, held_v));
        held = 1'b0;
      end
      if (wr_valid_o && !wr_ready_i) begin
        check(!req_ready_o, "R10", $sformatf("req_ready_o=%b exp 0 during stall", req_ready_o));
        held   = 1'b1;
        held_v = {wr_addr_o, wr_data_o, wr_be_o, wr_err_o};
      end
      if (wr_valid_o && wr_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "write with no request pending");
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(wr_addr_o == e.addr, t, $sformatf("addr got %h exp %h", wr_addr_o, e.addr));
          check(wr_be_o == e.be && wr_err_o == e.err, t,
                $sformatf("be/err got %b/%b exp %b/%b", wr_be_o, wr_err_o, e.be, e.err));
          check(wr_data_o == e.data, t, $sformatf("data got %h exp %h", wr_data_o, e.data));
        end
      end
    end
  end

  initial begin
    #50000000;
    check(1'b0, "WDOG", "watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #4;
    // R1
    check(wr_valid_o == 1'b0 && req_ready_o == 1'b1, "R1",
          $sformatf("valid/ready got %b/%b exp 0/1", wr_valid_o, req_ready_o));

    // every op at every offset, ready always high
    for (int op = 0; op < 5; op++) begin
      for (int k = 0; k < 4; k++) begin
        string t;
        case (op)
          0: t = "R3"; 1: t = "R4"; 2: t = "R5"; 3: t = "R6"; default: t = "R7";
        endcase
        if ((op == 1 && k % 2 == 1) || (op == 2 && k != 0)) t = "R8";
        send(3'(op), 20'h01230, 16'(k), 32'h44332211, t);
      end
    end
    // R2: negative displacement and wraparound
    send(3'd3, 20'h00105, 16'hFFF0, 32'hA1B2C3D4, "R2");
    send(3'd4, 20'hFFFFE, 16'h0007, 32'hCAFEF00D, "R2");
    send(3'd2, 20'h00000, 16'h8000, 32'h12345678, "R2");
    // R8: unknown op codes
    send(3'd5, 20'h00400, 16'h0000, 32'hFFFFFFFF, "R8");
    send(3'd7, 20'h00401, 16'h0001, 32'hFFFFFFFF, "R8");
    // R9: zero lanes with all-ones register
    send(3'd0, 20'h00777, 16'h0000, 32'hFFFFFFFF, "R9");
    send(3'd6, 20'h00000, 16'h0000, 32'hFFFFFFFF, "R9");

    // R10: random downstream stalls
    rdy_random = 1'b1;
    for (int i = 0; i < 60; i++) begin
      send(3'(i % 5), 20'(i * 37), 16'(i * 13), 32'h9E3779B9 ^ 32'(i * 32'h01010101), "R10");
    end
    rdy_random = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    #4;
    check(wr_valid_o == 1'b0, "R10", $sformatf("valid after drain got %b exp 0", wr_valid_o));
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule